// File: doc/BRIEF.md
# Load-Use Stall Controller

This block finds the one data hazard that forwarding cannot fix in a five-stage in-order pipeline: an instruction in decode that needs a register a load in execute has not yet read from memory. When it sees one, it freezes the front end of the pipeline for a single cycle. The program counter and the fetch/decode register keep their values, and a no-operation enters the decode/execute register. The stages behind keep moving, so the load reaches memory while the consumer waits one slot. The consumer then enters execute just as the loaded value can be forwarded to it.

The hazard logic sits beside a small register-level model of the pipeline. The model has a program counter, a fetch/decode register, a decode/execute register and a shift chain for the memory and writeback stages. Instructions come in at the fetch port, one per program-counter value. Each carries two source indices, a destination index, a write-enable, a load flag and an identifying tag. The tags of the instructions in execute and in writeback are visible at the ports, so the effect of each stall on timing can be seen from outside.

Top module: `loadUseGuard`

## Requirements
- R1: The three stall strobes (pcHold, ifIdHold, bubbleInsert) are all high in a cycle exactly when decode holds a valid instruction, execute holds a valid load with write-enable set and a nonzero destination, and that destination equals either source index of the decode instruction. In every other cycle all three are low.
- R2: A stall lasts exactly one cycle. The consuming instruction enters execute two cycles after its producing load entered execute.
- R3: In a stall cycle the fetch/decode register keeps its contents, so the fetched instruction is not lost.
- R4: In a stall cycle the program counter keeps its value.
- R5: The cycle after a stall, the execute stage holds a no-operation (exValid low).
- R6: A producer whose destination index is 0 never causes a stall.
- R7: A producer whose write-enable is low never causes a stall.
- R8: A non-load producer in execute never causes a stall, even when its destination matches.
- R9: When both source indices match the load's destination, only one bubble is inserted.
- R10: While rst is high at a clock edge, the block clears the program counter to 0, empties every pipeline register, and drives all strobes low after that edge.
- R11: During a stall the load in execute still moves on to the memory stage.
- R12: Every fetched valid instruction reaches writeback once, in program order, on the cycle given by its index plus the number of stalls up to and including it, plus four.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetchValid | input | 1 | Fetch port carries a real instruction |
| fetchRs1 | input | 5 | First source register index |
| fetchRs2 | input | 5 | Second source register index |
| fetchRd | input | 5 | Destination register index |
| fetchWe | input | 1 | Instruction writes its destination |
| fetchLoad | input | 1 | Instruction is a memory load |
| fetchTag | input | 8 | Identifying tag carried down the pipeline |
| pcOut | output | 8 | Current program counter |
| pcHold | output | 1 | Program counter frozen this cycle |
| ifIdHold | output | 1 | Fetch/decode register frozen this cycle |
| bubbleInsert | output | 1 | No-operation loaded into decode/execute |
| exValid | output | 1 | Execute stage holds a real instruction |
| exTag | output | 8 | Tag of the execute-stage instruction |
| wbValid | output | 1 | Writeback stage holds a real instruction |
| wbTag | output | 8 | Tag of the writeback-stage instruction |

## Verification
The assertions assume that the fetch port presents a stable instruction for the current program counter value throughout each cycle, and that reset is held for at least one edge before use. The bench meets both. It drives the fetch fields combinationally from small program tables indexed by pcOut, and it releases reset only on a falling edge after two held rising edges. The programs cover a single dependent consumer, dependent loads back to back, a consumer that matches on both sources, and a consumer two slots away. They also cover producers that write register 0, that do not write, or that are not loads. The programs are short, so the counter never wraps inside a run.

// File: rtl/luPkg.sv
`timescale 1ns/1ps
package luPkg;
  localparam int unsigned REG_W   = 5;
  localparam int unsigned TAG_W   = 8;
  localparam int unsigned NUM_SRC = 2;

  // instruction as it sits in fetch/decode: full operand set
  typedef struct packed {
    logic             valid;
    logic [REG_W-1:0] rs1;
    logic [REG_W-1:0] rs2;
    logic [REG_W-1:0] rd;
    logic             we;
    logic             isLoad;
    logic [TAG_W-1:0] tag;
  } decInstr_t;

  // instruction in execute: only what the hazard check and tracking need
  typedef struct packed {
    logic             valid;
    logic [REG_W-1:0] rd;
    logic             we;
    logic             isLoad;
    logic [TAG_W-1:0] tag;
  } exInstr_t;

  // memory and writeback stages only carry identity
  typedef struct packed {
    logic             valid;
    logic [TAG_W-1:0] tag;
  } lateInstr_t;

  // control-to-datapath strobes
  typedef struct packed {
    logic pcHold;
    logic ifIdHold;
    logic bubble;
  } stallStrobe_t;

  localparam decInstr_t  DEC_NOP  = '0;
  localparam exInstr_t   EX_NOP   = '0;
  localparam lateInstr_t LATE_NOP = '0;
endpackage

// File: rtl/luHazardCtl.sv
`timescale 1ns/1ps
module luHazardCtl
  import luPkg::*;
(
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          decValid,
  input  logic [NUM_SRC-1:0][REG_W-1:0] decSrc,
  input  logic                          exValid,
  input  logic                          exWe,
  input  logic                          exLoad,
  input  logic [REG_W-1:0]              exRd,
  output stallStrobe_t                  strobes
);

  logic               producerLive;
  logic [NUM_SRC-1:0] srcHit;
  logic               loadUse;

  // a producer only matters if it is a real load that writes a nonzero register
  assign producerLive = exValid && exWe && exLoad && (exRd != '0);

  generate
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      assign srcHit[s] = decValid && producerLive && (decSrc[s] == exRd);
    end
  endgenerate

  // any number of matching sources gives a single stall
  assign loadUse = |srcHit;

  always_comb begin
    strobes          = '0;
    strobes.pcHold   = loadUse;
    strobes.ifIdHold = loadUse;
    strobes.bubble   = loadUse;
  end

  AST_SINGLE_BUBBLE: assert property (@(posedge clk) disable iff (rst)
    strobes.bubble |=> !strobes.bubble); // R2

endmodule

// File: rtl/luPipeModel.sv
`timescale 1ns/1ps
module luPipeModel
  import luPkg::*;
#(
  parameter int unsigned PC_W        = 8,
  parameter int unsigned LATE_STAGES = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  decInstr_t                     fetchInstr,
  input  stallStrobe_t                  strobes,
  output logic [PC_W-1:0]               pcOut,
  output logic                          decValid,
  output logic [NUM_SRC-1:0][REG_W-1:0] decSrc,
  output exInstr_t                      exInstr,
  output lateInstr_t                    retireInstr
);

  logic [PC_W-1:0]                  pcQ;
  decInstr_t                        ifIdQ;
  exInstr_t                         idExQ;
  lateInstr_t [LATE_STAGES-1:0]     lateQ;

  // program counter: frozen during a stall
  always_ff @(posedge clk) begin
    if (rst)                  pcQ <= '0;
    else if (!strobes.pcHold) pcQ <= pcQ + 1'b1;
  end

  // fetch/decode register: keeps the fetched instruction during a stall
  always_ff @(posedge clk) begin
    if (rst)                    ifIdQ <= DEC_NOP;
    else if (!strobes.ifIdHold) ifIdQ <= fetchInstr;
  end

  // decode/execute register: receives a no-operation as the bubble
  always_ff @(posedge clk) begin
    if (rst || strobes.bubble) begin
      idExQ <= EX_NOP;
    end else begin
      idExQ.valid  <= ifIdQ.valid;
      idExQ.rd     <= ifIdQ.rd;
      idExQ.we     <= ifIdQ.we;
      idExQ.isLoad <= ifIdQ.isLoad;
      idExQ.tag    <= ifIdQ.tag;
    end
  end

  // memory and writeback stages never stall
  always_ff @(posedge clk) begin
    if (rst) begin
      lateQ <= '0;
    end else begin
      for (int l = 0; l < int'(LATE_STAGES); l++) begin
        if (l == 0) lateQ[l] <= '{valid: idExQ.valid, tag: idExQ.tag};
        else        lateQ[l] <= lateQ[l-1];
      end
    end
  end

  assign pcOut       = pcQ;
  assign decValid    = ifIdQ.valid;
  assign decSrc      = {ifIdQ.rs2, ifIdQ.rs1};
  assign exInstr     = idExQ;
  assign retireInstr = lateQ[LATE_STAGES-1];

  AST_STROBES_AGREE: assert property (@(posedge clk) disable iff (rst)
    (strobes.pcHold == strobes.bubble) && (strobes.ifIdHold == strobes.bubble)); // R1
  AST_DECODE_HELD: assert property (@(posedge clk) disable iff (rst)
    strobes.ifIdHold |=> (ifIdQ == $past(ifIdQ))); // R3
  AST_PC_FROZEN: assert property (@(posedge clk) disable iff (rst)
    strobes.pcHold |=> (pcQ == $past(pcQ))); // R4
  AST_EXEC_NOP: assert property (@(posedge clk) disable iff (rst)
    strobes.bubble |=> !idExQ.valid); // R5
  AST_NO_ZERO_DEST: assert property (@(posedge clk) disable iff (rst)
    strobes.bubble |-> (idExQ.rd != '0)); // R6
  AST_NO_DEAD_WRITE: assert property (@(posedge clk) disable iff (rst)
    strobes.bubble |-> idExQ.we); // R7
  AST_ONLY_LOADS: assert property (@(posedge clk) disable iff (rst)
    strobes.bubble |-> (idExQ.isLoad && idExQ.valid)); // R8
  AST_PRODUCER_ADVANCES: assert property (@(posedge clk) disable iff (rst)
    strobes.bubble |=> (lateQ[0].valid && (lateQ[0].tag == $past(idExQ.tag)))); // R11
  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> ((pcQ == '0) && !ifIdQ.valid && !idExQ.valid && !strobes.bubble)); // R10

endmodule

// File: rtl/loadUseGuard.sv
`timescale 1ns/1ps
module loadUseGuard
  import luPkg::*;
#(
  parameter int unsigned PC_W        = 8,
  parameter int unsigned LATE_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fetchValid,
  input  logic [REG_W-1:0] fetchRs1,
  input  logic [REG_W-1:0] fetchRs2,
  input  logic [REG_W-1:0] fetchRd,
  input  logic             fetchWe,
  input  logic             fetchLoad,
  input  logic [TAG_W-1:0] fetchTag,
  output logic [PC_W-1:0]  pcOut,
  output logic             pcHold,
  output logic             ifIdHold,
  output logic             bubbleInsert,
  output logic             exValid,
  output logic [TAG_W-1:0] exTag,
  output logic             wbValid,
  output logic [TAG_W-1:0] wbTag
);

  decInstr_t                     fetchInstr;
  stallStrobe_t                  strobes;
  logic                          decValid;
  logic [NUM_SRC-1:0][REG_W-1:0] decSrc;
  exInstr_t                      exInstr;
  lateInstr_t                    retireInstr;

  always_comb begin
    fetchInstr.valid  = fetchValid;
    fetchInstr.rs1    = fetchRs1;
    fetchInstr.rs2    = fetchRs2;
    fetchInstr.rd     = fetchRd;
    fetchInstr.we     = fetchWe;
    fetchInstr.isLoad = fetchLoad;
    fetchInstr.tag    = fetchTag;
  end

  luHazardCtl i_ctl (
    .clk      (clk),
    .rst      (rst),
    .decValid (decValid),
    .decSrc   (decSrc),
    .exValid  (exInstr.valid),
    .exWe     (exInstr.we),
    .exLoad   (exInstr.isLoad),
    .exRd     (exInstr.rd),
    .strobes  (strobes)
  );

  luPipeModel #(
    .PC_W        (PC_W),
    .LATE_STAGES (LATE_STAGES)
  ) i_pipe (
    .clk         (clk),
    .rst         (rst),
    .fetchInstr  (fetchInstr),
    .strobes     (strobes),
    .pcOut       (pcOut),
    .decValid    (decValid),
    .decSrc      (decSrc),
    .exInstr     (exInstr),
    .retireInstr (retireInstr)
  );

  assign pcHold       = strobes.pcHold;
  assign ifIdHold     = strobes.ifIdHold;
  assign bubbleInsert = strobes.bubble;
  assign exValid      = exInstr.valid;
  assign exTag        = exInstr.tag;
  assign wbValid      = retireInstr.valid;
  assign wbTag        = retireInstr.tag;

endmodule

// File: tb/test_loadUseGuard.sv
`timescale 1ns/1ps
module test_loadUseGuard;
  localparam int PC_W = 8;
  localparam int MAXP = 16;
  localparam int WIN  = 64;

  typedef struct { logic [7:0] tag; int due; } expItem_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  // program tables
  logic [4:0] pRs1 [MAXP];
  logic [4:0] pRs2 [MAXP];
  logic [4:0] pRd  [MAXP];
  logic       pWe  [MAXP];
  logic       pLd  [MAXP];
  logic [7:0] pTag [MAXP];
  int         progLen = 0;
  int         tagBase = 16;

  logic            fValid, fWe, fLoad;
  logic [4:0]      fRs1, fRs2, fRd;
  logic [7:0]      fTag;
  logic [PC_W-1:0] pcOut;
  logic            pcHold, ifIdHold, bubbleInsert, exValid, wbValid;
  logic [7:0]      exTag, wbTag;

  logic pcInRange;
  assign pcInRange = (int'(pcOut) < progLen);
  assign fValid = pcInRange;
  assign fRs1   = pcInRange ? pRs1[pcOut[3:0]] : '0;
  assign fRs2   = pcInRange ? pRs2[pcOut[3:0]] : '0;
  assign fRd    = pcInRange ? pRd[pcOut[3:0]]  : '0;
  assign fWe    = pcInRange ? pWe[pcOut[3:0]]  : 1'b0;
  assign fLoad  = pcInRange ? pLd[pcOut[3:0]]  : 1'b0;
  assign fTag   = pcInRange ? pTag[pcOut[3:0]] : '0;

  loadUseGuard i_loadUseGuard (
    .clk(clk), .rst(rst),
    .fetchValid(fValid), .fetchRs1(fRs1), .fetchRs2(fRs2), .fetchRd(fRd),
    .fetchWe(fWe), .fetchLoad(fLoad), .fetchTag(fTag),
    .pcOut(pcOut), .pcHold(pcHold), .ifIdHold(ifIdHold), .bubbleInsert(bubbleInsert),
    .exValid(exValid), .exTag(exTag), .wbValid(wbValid), .wbTag(wbTag)
  );

  int       nChecks = 0;
  int       nFail   = 0;
  bit       finished = 0;
  bit       monOn = 0;
  string    curReq = "";
  int       edgeCnt = 0;
  bit       stallAt [WIN];
  expItem_t expQ [$];

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (rst) edgeCnt <= 0;
    else     edgeCnt <= edgeCnt + 1;
  end

  // monitor: samples a quarter period after each rising edge
  always @(posedge clk) begin
    #1;
    if (!rst && monOn) begin
      bit expS, prevS;
      expS  = (edgeCnt < WIN) ? stallAt[edgeCnt] : 1'b0;
      prevS = (edgeCnt > 0 && edgeCnt <= WIN) ? stallAt[edgeCnt-1] : 1'b0;
      check(pcHold == expS,       "R4", "pcHold",       int'(pcHold),       int'(expS));
      check(ifIdHold == expS,     "R3", "ifIdHold",     int'(ifIdHold),     int'(expS));
      check(bubbleInsert == expS, "R1", "bubbleInsert", int'(bubbleInsert), int'(expS));
      if (prevS) check(!exValid, "R5", "exValid after stall", int'(exValid), 0);
      if (wbValid) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R12", "unexpected retire tag", int'(wbTag), -1);
        end else begin
          expItem_t it;
          it = expQ.pop_front();
          check(wbTag == it.tag, "R12", "retire order tag", int'(wbTag), int'(it.tag));
          check(edgeCnt == it.due, curReq, "retire cycle", edgeCnt, it.due);
        end
      end
    end
  end

  task automatic setInstr(input int i, input int rs1, input int rs2, input int rd, input bit we, input bit ld);
    pRs1[i] = 5'(rs1); pRs2[i] = 5'(rs2); pRd[i] = 5'(rd);
    pWe[i] = we; pLd[i] = ld; pTag[i] = 8'(tagBase + i);
  endtask

  // driver: computes expected stalls and retire cycles, then runs the program
  task automatic runScenario(input string req, input int len);
    int sb;
    sb = 0;
    progLen = len;
    expQ.delete();
    for (int k = 0; k < WIN; k++) stallAt[k] = 1'b0;
    for (int i = 0; i < len; i++) begin
      bit st;
      st = 1'b0;
      if (i > 0 && pLd[i-1] && pWe[i-1] && pRd[i-1] != 0 &&
          (pRs1[i] == pRd[i-1] || pRs2[i] == pRd[i-1])) st = 1'b1;
      if (st) begin
        stallAt[1 + i + sb] = 1'b1;
        sb++;
      end
      expQ.push_back('{tag: pTag[i], due: 4 + i + sb});
    end
    curReq = req;
    monOn = 0;
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(pcOut == 0, "R10", "reset pcOut", int'(pcOut), 0);
    check(!exValid && !wbValid, "R10", "reset stage valid", int'(exValid || wbValid), 0);
    check(!pcHold && !ifIdHold && !bubbleInsert, "R10", "reset strobes",
          int'(pcHold || ifIdHold || bubbleInsert), 0);
    rst = 1'b0;
    monOn = 1;
    for (int g = 0; g < 200 && expQ.size() != 0; g++) @(posedge clk);
    check(expQ.size() == 0, "R12", "instructions not retired", expQ.size(), 0);
    repeat (6) @(posedge clk);
    @(negedge clk);
    monOn = 0;
    tagBase += MAXP;
  endtask

  initial begin
    for (int i = 0; i < MAXP; i++) setInstr(i, 0, 0, 0, 1'b0, 1'b0);
    // R1 R2 R11: one dependent consumer, then an ALU chain that forwards
    setInstr(0, 1, 0, 5, 1, 1);
    setInstr(1, 5, 2, 6, 1, 0);
    setInstr(2, 6, 3, 7, 1, 0);
    setInstr(3, 7, 0, 8, 1, 0);
    runScenario("R1 R2 R11", 4);
    // R2: match on second source, dependent loads back to back, both sources
    setInstr(0, 1, 0, 9, 1, 1);
    setInstr(1, 3, 9, 4, 1, 0);
    setInstr(2, 4, 0, 10, 1, 1);
    setInstr(3, 10, 0, 11, 1, 1);
    setInstr(4, 11, 11, 12, 1, 0);
    setInstr(5, 10, 0, 13, 1, 0);
    runScenario("R2 R3 R4 R5", 6);
    // R6: load to register 0 then a reader of register 0
    setInstr(0, 1, 0, 0, 1, 1);
    setInstr(1, 0, 0, 3, 1, 0);
    setInstr(2, 0, 3, 4, 1, 0);
    runScenario("R6", 3);
    // R7: load without write-enable
    setInstr(0, 1, 0, 5, 0, 1);
    setInstr(1, 5, 5, 6, 1, 0);
    runScenario("R7", 2);
    // R8: ALU producer with matching destination
    setInstr(0, 1, 2, 5, 1, 0);
    setInstr(1, 5, 5, 6, 1, 0);
    setInstr(2, 6, 5, 7, 1, 0);
    runScenario("R8", 3);
    // R9: both sources match, then a consumer two slots behind a load
    setInstr(0, 2, 0, 7, 1, 1);
    setInstr(1, 7, 7, 8, 1, 0);
    setInstr(2, 1, 0, 13, 1, 1);
    setInstr(3, 2, 3, 14, 1, 0);
    setInstr(4, 13, 0, 15, 1, 0);
    runScenario("R9", 5);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
      $finish;
    end
  end

endmodule